// File: doc/BRIEF.md
# Interrupt Line Controller with Priority Arbitration

This block manages a bank of external interrupt lines for a small processor core. Each line has an enable bit, a pending bit, an active bit and a small priority value, all reachable through a 32-bit word-addressed register port. Enable and pending state are changed only by writing ones. One address turns bits on and a different address turns them off, so software never needs a read-modify-write to touch one line. A level-high input that is asserted marks its line pending.

Every cycle the block works out which enabled, pending line is most urgent. It offers that line to the core as an exception number (line index plus 16), but only when the line is strictly more urgent than every exception already active. An offer FSM has two states. From `IDLE` it moves to `HOLD` on **arm**, when a candidate exists. From `HOLD` it returns to `IDLE` on **withdraw**, when the held line is no longer the best candidate, or on **take**, when the core acknowledges the offer. A take clears the line's pending bit and marks it active. A completion strobe from the core, carrying the exception number, clears the active bit. A status word reports the most urgent active exception, or 0 when the core runs in thread mode.

Top module: `irqc_top`

## Requirements
- R1: Writing word address 0 (enable-set) turns on every line whose data bit is 1 and leaves the others unchanged. Addresses 0 and 1 both read back the 32-bit enable mask, with bit n belonging to line n.
- R2: Writing word address 1 (enable-clear) turns off every line whose data bit is 1 and leaves the others unchanged.
- R3: Writing ones to word address 2 (pend-set) marks those lines pending, and writing ones to word address 3 (pend-clear) unmarks them. Both addresses read back the pending mask.
- R4: Line n has a 2-bit priority at bits [8*(n%4)+7 : 8*(n%4)+6] of priority word n/4, which is word address 8+n/4. All other bits of the priority words read as 0 and ignore writes.
- R5: Only lines that are both enabled and pending are offered. Among them, the lowest priority value wins, and on equal values the lowest line index wins.
- R6: A line is offered only while its priority value is strictly lower than that of every active line. The offer shows `req_valid` high with `req_num` = line index + 16, starting in the second cycle after the line becomes pending.
- R7: Asserting `req_ack` while `req_valid` is high clears that line's pending bit and sets it active. From the next cycle, the low 6 bits of word address 4 (status) read the exception number of the most urgent active line, and read 0 when no line is active.
- R8: A pending set from a high `irq_in` bit or from a pend-set write takes precedence over a clear in the same cycle. A level input still high during its acknowledge leaves the line pending.
- R9: A `done_valid` pulse with `done_num` = n+16 clears line n's active bit. The status word then returns to the next active line, or to 0.
- R10: After reset all enables, pendings, actives and priorities are 0, no offer is made, and status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_LINES | Level-high interrupt inputs |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| req_valid | output | 1 | An exception is offered to the core |
| req_num | output | EXC_W | Offered exception number |
| req_ack | input | 1 | Core takes the offered exception |
| done_valid | input | 1 | Core finished an exception |
| done_num | input | EXC_W | Exception number that finished |

## Verification
The main collision is an acknowledge that clears a line's pending bit in the same cycle that something sets that bit again. The bench provokes it twice. First it holds a line's level input high through the acknowledge. Then it writes the pend-set address on the exact cycle `req_ack` is high. In both cases it reads the pending mask on the next cycle and expects the bit still set, while status shows the line as active and no new offer appears for it. The bench also withdraws an offer by disabling the line while the offer is held, and expects `req_valid` to drop right after the write.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Word addresses of the register port
    localparam int A_EN_SET    = 0;
    localparam int A_EN_CLR    = 1;
    localparam int A_PEND_SET  = 2;
    localparam int A_PEND_CLR  = 3;
    localparam int A_STATUS    = 4;
    localparam int A_PRIO_BASE = 8;

    // Offer state machine
    typedef enum logic [0:0] {
        OFF_IDLE = 1'b0,
        OFF_HOLD = 1'b1
    } offer_state_e;

endpackage

// File: rtl/irqc_select.sv
// Picks the candidate with the lowest priority value; ties go to the lowest index.
module irqc_select #(
    parameter int NUM_LINES = 32,
    parameter int PRIO_W    = 2,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0]        cand,
    input  logic [NUM_LINES*PRIO_W-1:0] prio_flat,
    output logic                        found,
    output logic [IDX_W-1:0]            idx,
    output logic [PRIO_W:0]             best_prio
);

    always_comb begin
        best_prio         = '0;
        best_prio[PRIO_W] = 1'b1;
        idx               = '0;
        found             = 1'b0;
        for (int n = NUM_LINES - 1; n >= 0; n--) begin
            if (cand[n] && ({1'b0, prio_flat[n*PRIO_W +: PRIO_W]} <= best_prio)) begin
                best_prio = {1'b0, prio_flat[n*PRIO_W +: PRIO_W]};
                idx       = IDX_W'(n);
                found     = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irqc_line_bank.sv
// Per-line enable, pending, active and priority storage.
module irqc_line_bank #(
    parameter int NUM_LINES = 32,
    parameter int PRIO_W    = 2,
    localparam int PRIO_REGS = NUM_LINES / 4,
    localparam int SEL_W     = (PRIO_REGS > 1) ? $clog2(PRIO_REGS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINES-1:0]        en_set,
    input  logic [NUM_LINES-1:0]        en_clr,
    input  logic [NUM_LINES-1:0]        pend_set,
    input  logic [NUM_LINES-1:0]        pend_clr,
    input  logic [NUM_LINES-1:0]        act_set,
    input  logic [NUM_LINES-1:0]        act_clr,
    input  logic                        prio_we,
    input  logic [SEL_W-1:0]            prio_sel,
    input  logic [31:0]                 prio_wdata,
    output logic [NUM_LINES-1:0]        en_q,
    output logic [NUM_LINES-1:0]        pend_q,
    output logic [NUM_LINES-1:0]        act_q,
    output logic [NUM_LINES*PRIO_W-1:0] prio_flat
);

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        localparam int LANE_TOP = 8 * (n % 4) + 7;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[n]   <= 1'b0;
                pend_q[n] <= 1'b0;
                act_q[n]  <= 1'b0;
                prio_flat[n*PRIO_W +: PRIO_W] <= '0;
            end else begin
                if (en_set[n])      en_q[n] <= 1'b1;
                else if (en_clr[n]) en_q[n] <= 1'b0;
                // a set in the same cycle wins over a clear
                pend_q[n] <= (pend_q[n] & ~pend_clr[n]) | pend_set[n];
                if (act_set[n])      act_q[n] <= 1'b1;
                else if (act_clr[n]) act_q[n] <= 1'b0;
                if (prio_we && (prio_sel == SEL_W'(n / 4)))
                    prio_flat[n*PRIO_W +: PRIO_W] <= prio_wdata[LANE_TOP -: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/irqc_offer_fsm.sv
// Holds one offered line towards the core until it is taken or withdrawn.
module irqc_offer_fsm
    import irqc_pkg::*;
#(
    parameter int NUM_LINES = 32,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             best_found,
    input  logic [IDX_W-1:0] best_idx,
    input  logic             ack,
    output logic             req_valid,
    output logic             take,
    output logic [IDX_W-1:0] held_idx
);

    offer_state_e state_q, state_d;
    logic         still_best;

    assign still_best = best_found && (best_idx == held_idx);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OFF_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                    held_idx <= '0;
        else if (state_q == OFF_IDLE && best_found)    held_idx <= best_idx;
    end

    // next state: arm, withdraw, take
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OFF_IDLE: if (best_found)            state_d = OFF_HOLD;
            OFF_HOLD: if (!still_best || ack)    state_d = OFF_IDLE;
            default:                             state_d = OFF_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_valid = 1'b0;
        unique case (state_q)
            OFF_IDLE: req_valid = 1'b0;
            OFF_HOLD: req_valid = still_best;
            default:  req_valid = 1'b0;
        endcase
        take = req_valid && ack;
    end

    // R7
    take_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !req_valid);

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int PRIO_W    = 2,
    localparam int IDX_W     = $clog2(NUM_LINES),
    localparam int EXC_W     = $clog2(NUM_LINES + 16),
    localparam int PRIO_REGS = NUM_LINES / 4,
    localparam int SEL_W     = (PRIO_REGS > 1) ? $clog2(PRIO_REGS) : 1,
    localparam int ADDR_W    = $clog2(A_PRIO_BASE + PRIO_REGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 reg_wr_en,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 req_valid,
    output logic [EXC_W-1:0]     req_num,
    input  logic                 req_ack,
    input  logic                 done_valid,
    input  logic [EXC_W-1:0]     done_num
);

    logic [NUM_LINES-1:0]        en_q, pend_q, act_q;
    logic [NUM_LINES*PRIO_W-1:0] prio_flat;
    logic [NUM_LINES-1:0]        en_set, en_clr, pend_set, pend_clr, act_set, act_clr;
    logic [NUM_LINES-1:0]        below_act, eligible;
    logic                        is_prio, take, sel_found, act_found;
    logic [SEL_W-1:0]            prio_idx;
    logic [IDX_W-1:0]            sel_idx, act_idx, held_idx;
    logic [PRIO_W:0]             sel_prio, act_prio;
    logic [EXC_W-1:0]            done_line, status_num;
    logic                        done_hit;

    // write decode
    assign is_prio  = (reg_addr >= ADDR_W'(A_PRIO_BASE)) &&
                      ((reg_addr - ADDR_W'(A_PRIO_BASE)) < ADDR_W'(PRIO_REGS));
    assign prio_idx = SEL_W'(reg_addr - ADDR_W'(A_PRIO_BASE));

    assign en_set   = (reg_wr_en && reg_addr == ADDR_W'(A_EN_SET))   ? reg_wdata[NUM_LINES-1:0] : '0;
    assign en_clr   = (reg_wr_en && reg_addr == ADDR_W'(A_EN_CLR))   ? reg_wdata[NUM_LINES-1:0] : '0;
    assign pend_set = irq_in |
                      ((reg_wr_en && reg_addr == ADDR_W'(A_PEND_SET)) ? reg_wdata[NUM_LINES-1:0] : '0);
    assign pend_clr = act_set |
                      ((reg_wr_en && reg_addr == ADDR_W'(A_PEND_CLR)) ? reg_wdata[NUM_LINES-1:0] : '0);
    assign act_set  = take ? (NUM_LINES'(1) << held_idx) : '0;

    assign done_line = done_num - EXC_W'(16);
    assign done_hit  = done_valid && (done_num >= EXC_W'(16)) && (done_line < EXC_W'(NUM_LINES));
    assign act_clr   = done_hit ? (NUM_LINES'(1) << done_line) : '0;

    irqc_line_bank #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_set     (en_set),
        .en_clr     (en_clr),
        .pend_set   (pend_set),
        .pend_clr   (pend_clr),
        .act_set    (act_set),
        .act_clr    (act_clr),
        .prio_we    (reg_wr_en && is_prio),
        .prio_sel   (prio_idx),
        .prio_wdata (reg_wdata),
        .en_q       (en_q),
        .pend_q     (pend_q),
        .act_q      (act_q),
        .prio_flat  (prio_flat)
    );

    // most urgent active line sets the preemption threshold
    irqc_select #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_act_sel (
        .cand      (act_q),
        .prio_flat (prio_flat),
        .found     (act_found),
        .idx       (act_idx),
        .best_prio (act_prio)
    );

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_thresh
        assign below_act[n] = {1'b0, prio_flat[n*PRIO_W +: PRIO_W]} < act_prio;
    end
    assign eligible = en_q & pend_q & below_act;

    irqc_select #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_req_sel (
        .cand      (eligible),
        .prio_flat (prio_flat),
        .found     (sel_found),
        .idx       (sel_idx),
        .best_prio (sel_prio)
    );

    irqc_offer_fsm #(.NUM_LINES(NUM_LINES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .best_found (sel_found),
        .best_idx   (sel_idx),
        .ack        (req_ack),
        .req_valid  (req_valid),
        .take       (take),
        .held_idx   (held_idx)
    );

    assign req_num    = EXC_W'(held_idx) + EXC_W'(16);
    assign status_num = act_found ? (EXC_W'(act_idx) + EXC_W'(16)) : '0;

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (is_prio) begin
            for (int k = 0; k < 4; k++)
                reg_rdata[8*k+7 -: PRIO_W] = prio_flat[(int'(prio_idx)*4 + k)*PRIO_W +: PRIO_W];
        end else begin
            unique case (int'(reg_addr))
                A_EN_SET, A_EN_CLR:     reg_rdata[NUM_LINES-1:0] = en_q;
                A_PEND_SET, A_PEND_CLR: reg_rdata[NUM_LINES-1:0] = pend_q;
                A_STATUS:               reg_rdata[EXC_W-1:0]     = status_num;
                default:                reg_rdata = '0;
            endcase
        end
    end

    // R1
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == ADDR_W'(A_EN_SET))
        |=> ((en_q & $past(reg_wdata[NUM_LINES-1:0])) == $past(reg_wdata[NUM_LINES-1:0])));

    // R2
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == ADDR_W'(A_EN_CLR))
        |=> ((en_q & $past(reg_wdata[NUM_LINES-1:0])) == '0));

    // R5
    req_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (en_q[held_idx] && pend_q[held_idx]));

    // R6
    preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && act_found) |-> (sel_prio < act_prio));

    // R7
    take_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ack) |=> (status_num != '0));

    // R8
    level_repend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ack && irq_in[held_idx]) |=> pend_q[$past(held_idx)]);

endmodule

// File: tb/tb_irqc_top.sv
`timescale 1ns/1ps
module tb_irqc_top;

    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid;
    logic [5:0]  req_num;
    logic        req_ack = 1'b0;
    logic        done_valid = 1'b0;
    logic [5:0]  done_num = '0;

    int n_chk = 0;
    int n_bad = 0;

    irqc_top dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .req_valid(req_valid), .req_num(req_num),
        .req_ack(req_ack), .done_valid(done_valid), .done_num(done_num)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 4'(a);
        #1 d = reg_rdata;
    endtask

    task automatic ack();
        @(negedge clk);
        req_ack = 1'b1;
        @(negedge clk);
        req_ack = 1'b0;
    endtask

    task automatic done(input int num);
        @(negedge clk);
        done_valid = 1'b1; done_num = 6'(num);
        @(negedge clk);
        done_valid = 1'b0;
    endtask

    function automatic int pr(input int n);
        return (n * 3 + 1) % 4;
    endfunction

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d, w;
        repeat (3) step();
        rst_n = 1'b1;

        // R10 reset state
        rd(0, d); chk("R10 enable", d, 0);
        rd(2, d); chk("R10 pending", d, 0);
        rd(4, d); chk("R10 status", d, 0);
        rd(8, d); chk("R10 prio", d, 0);
        chk("R10 req_valid", 32'(req_valid), 0);

        // R1 enable-set
        wr(0, 32'h0000_0320);
        rd(0, d); chk("R1 set", d, 32'h320);
        rd(1, d); chk("R1 alias", d, 32'h320);
        wr(0, 32'h1);
        rd(0, d); chk("R1 keep", d, 32'h321);
        // R2 enable-clear
        wr(1, 32'h100);
        rd(0, d); chk("R2 clr one", d, 32'h221);
        wr(1, 32'hFFFF_FFFF);
        rd(1, d); chk("R2 clr all", d, 0);

        // R4 priority field placement sweep
        for (int r = 0; r < 8; r++) begin
            wr(8 + r, 32'hFFFF_FFFF);
            rd(8 + r, d); chk("R4 mask", d, 32'hC0C0_C0C0);
        end
        for (int r = 0; r < 8; r++) begin
            w = 0;
            for (int k = 0; k < 4; k++) w |= 32'(pr(4*r + k)) << (8*k + 6);
            wr(8 + r, w | 32'h3F3F_3F3F);
            rd(8 + r, d); chk("R4 field", d, w);
        end

        // R3 pending set / clear, no enables so no offer
        wr(2, 32'hA5);
        rd(2, d); chk("R3 set", d, 32'hA5);
        rd(3, d); chk("R3 alias", d, 32'hA5);
        step(); chk("R5 not enabled", 32'(req_valid), 0);
        wr(3, 32'hFF);
        rd(2, d); chk("R3 clr", d, 0);

        // R6 R7 R9 single-line sweep
        for (int n = 0; n < N; n++) begin
            wr(1, 32'hFFFF_FFFF);
            wr(0, 32'h1 << n);
            wr(2, 32'h1 << n);
            step();
            chk("R6 valid", 32'(req_valid), 1);
            chk("R6 number", 32'(req_num), 32'(n + 16));
            ack();
            rd(4, d); chk("R7 status", d, 32'(n + 16));
            rd(2, d); chk("R7 pend cleared", d, 0);
            done(n + 16);
            rd(4, d); chk("R9 status idle", d, 0);
        end

        // R5 ordering: all lines pending, priorities pr(n)
        wr(0, 32'hFFFF_FFFF);
        wr(2, 32'hFFFF_FFFF);
        for (int p = 0; p < 4; p++) begin
            for (int n = 0; n < N; n++) begin
                if (pr(n) == p) begin
                    step();
                    chk("R5 order", 32'(req_num), 32'(n + 16));
                    chk("R5 valid", 32'(req_valid), 1);
                    ack();
                    done(n + 16);
                end
            end
        end
        step(); chk("R5 drained", 32'(req_valid), 0);

        // R6 nesting: line5 p2, line9 p2, line14 p0
        wr(1, 32'hFFFF_FFFF);
        for (int r = 0; r < 8; r++) wr(8 + r, 0);
        wr(9, 32'h2 << 14);
        wr(10, 32'h2 << 14);
        wr(0, (32'h1 << 5) | (32'h1 << 9) | (32'h1 << 14));
        wr(2, 32'h1 << 5);
        step(); chk("R6 first", 32'(req_num), 21);
        ack();
        wr(2, 32'h1 << 9);
        step(); chk("R6 equal no preempt", 32'(req_valid), 0);
        wr(2, 32'h1 << 14);
        step(); chk("R6 preempt", 32'(req_num), 30);
        chk("R6 preempt valid", 32'(req_valid), 1);
        ack();
        rd(4, d); chk("R7 nested status", d, 30);
        done(30);
        rd(4, d); chk("R9 back to outer", d, 21);
        step(); chk("R6 still blocked", 32'(req_valid), 0);
        done(21);
        rd(4, d); chk("R9 thread", d, 0);
        step(); chk("R6 waiting line", 32'(req_num), 25);
        ack();
        done(25);

        // R8 level input held through acknowledge
        wr(1, 32'hFFFF_FFFF);
        wr(0, 32'h8);
        @(negedge clk); irq_in[3] = 1'b1;
        step(); step();
        chk("R8 level offer", 32'(req_num), 19);
        ack();
        rd(2, d); chk("R8 repend", d, 32'h8);
        rd(4, d); chk("R8 status", d, 19);
        chk("R8 no self offer", 32'(req_valid), 0);
        @(negedge clk); irq_in[3] = 1'b0;
        wr(3, 32'h8);
        rd(2, d); chk("R3 clr after level", d, 0);
        done(19);
        step(); step(); chk("R8 quiet", 32'(req_valid), 0);

        // R8 pend-set write in the acknowledge cycle
        wr(0, 32'h80);
        wr(2, 32'h80);
        step(); chk("R8 offer 7", 32'(req_num), 23);
        @(negedge clk);
        req_ack = 1'b1; reg_wr_en = 1'b1; reg_addr = 4'd2; reg_wdata = 32'h80;
        @(negedge clk);
        req_ack = 1'b0; reg_wr_en = 1'b0;
        rd(2, d); chk("R8 write wins", d, 32'h80);
        rd(4, d); chk("R8 status 7", d, 23);
        wr(3, 32'h80);
        done(23);

        // R5 withdraw when the line is disabled while offered
        wr(0, 32'h4);
        wr(2, 32'h4);
        step(); chk("R5 offer 2", 32'(req_num), 18);
        wr(1, 32'h4);
        chk("R5 withdrawn", 32'(req_valid), 0);
        step(); chk("R5 stays off", 32'(req_valid), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule